// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a fully associative translation buffer. It maps a virtual address to a physical address. Every entry stores a virtual page pair tag, an 8-bit address space identifier, a global flag for each half, a valid bit for each half, and two page frame numbers. One frame number covers the even 4 KB page of the pair and the other covers the odd page. A lookup presents the address, the identifier of the running context, the address width mode (32-bit or 64-bit) and a user/kernel flag. One clock later the block returns a physical address and exactly one of hit, miss or address error.

Entries are loaded through a write port by index. A write takes effect at the next clock edge. Entries marked global match any context, so a context switch only changes the identifier presented to the lookup port and needs no invalidation. When more than one entry matches, the lowest index wins.

Top module: `vtlb_top`

## Requirements
- R1: A lookup presented with `lk_req` high at a clock edge produces `rsp_vld` high after that edge. `rsp_vld` is low after any edge where `lk_req` was low.
- R2: When `rsp_vld` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_aerr` is high. When `rsp_vld` is low, all three are low.
- R3: In 32-bit mode (`lk_mode64`=0), only `lk_va[31:0]` is used and bits 63:32 are ignored. A user lookup (`lk_user`=1) with `lk_va[31]`=1 gives `rsp_aerr`=1, `rsp_hit`=0 and `rsp_miss`=0.
- R4: In 64-bit mode, a user lookup with any of `lk_va[63:40]` set gives `rsp_aerr`. A kernel lookup is never range-checked, and bits 63:40 take no part in its translation.
- R5: The effective address is `lk_va[39:0]` in 64-bit mode, or `lk_va[31:0]` zero-extended to 40 bits in 32-bit mode. Bits 39:13 of the effective address are compared against the 27-bit tag of every entry.
- R6: On a hit, `rsp_pa` = {selected 20-bit frame number, `lk_va[11:0]`}. When there is no hit, `rsp_pa` is 0.
- R7: An entry with both global flags set matches for any `lk_asid`. Any other entry matches only when its stored identifier equals `lk_asid`.
- R8: Effective address bit 12 selects the half of the matching entry: 0 selects the even half (`pfn0`, `v0`) and 1 selects the odd half (`pfn1`, `v1`).
- R9: When the winning entry's selected half is not valid, the result is a miss.
- R10: When several entries match, the lowest-index entry decides the result, including its valid bit.
- R11: A write with `wr_en` high at an edge is visible to lookups at later edges. A lookup at the same edge sees the old contents.
- R12: Reset clears every valid bit and every response output, so every in-range lookup after reset is a miss until entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Virtual address |
| lk_asid | input | 8 | Current context identifier |
| lk_mode64 | input | 1 | 1 = 64-bit address mode |
| lk_user | input | 1 | 1 = user access (range checked) |
| wr_en | input | 1 | Entry write enable |
| wr_idx | input | 5 | Entry index to write |
| wr_vpn2 | input | 27 | Page pair tag |
| wr_asid | input | 8 | Entry context identifier |
| wr_g0 | input | 1 | Global flag, even half |
| wr_g1 | input | 1 | Global flag, odd half |
| wr_v0 | input | 1 | Valid, even half |
| wr_v1 | input | 1 | Valid, odd half |
| wr_pfn0 | input | 20 | Frame number, even page |
| wr_pfn1 | input | 20 | Frame number, odd page |
| rsp_vld | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No usable translation |
| rsp_aerr | output | 1 | User address out of range |
| rsp_pa | output | 32 | Physical address |

## Verification
An entry load and a lookup of the page that the load targets can land on the same clock edge. The bench provokes this by driving both ports in one cycle with the lookup aimed at the entry being written. It expects the lookup to report the old contents, a miss for an empty slot, and the very next lookup to see the new entry. The bench also overwrites a slot at the same edge as a lookup that hits the slot's old contents, and it repeats such collisions many times with random stimulus. Each cycle's outputs are compared against a behavioural model that applies the write only after evaluating that cycle's lookup.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  parameter int VA_W    = 64;
  parameter int OFF_W   = 12;
  parameter int EA_W    = 40;
  parameter int U32_W   = 31;
  parameter int ASID_W  = 8;
  parameter int PFN_W   = 20;
  parameter int VPN2_W  = EA_W - OFF_W - 1;
  parameter int PA_W    = PFN_W + OFF_W;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic              g0;
    logic              g1;
    logic              v0;
    logic              v1;
    logic [PFN_W-1:0]  pfn0;
    logic [PFN_W-1:0]  pfn1;
  } tlb_ent_t;
endpackage

// File: rtl/vtlb_store.sv
module vtlb_store
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  tlb_ent_t                  wdata,
  output tlb_ent_t [ENTRIES-1:0]    ents_o
);
  tlb_ent_t           mem_q [ENTRIES];
  logic [ENTRIES-1:0] v0_q;
  logic [ENTRIES-1:0] v1_q;

  // payload fields carry no reset
  always_ff @(posedge clk) begin
    if (we) mem_q[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q <= '0;
      v1_q <= '0;
    end else if (we) begin
      v0_q[widx] <= wdata.v0;
      v1_q[widx] <= wdata.v1;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_out
    always_comb begin
      ents_o[i]    = mem_q[i];
      ents_o[i].v0 = v0_q[i];
      ents_o[i].v1 = v1_q[i];
    end
  end
endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic [VPN2_W-1:0]      tag,
  input  logic [ASID_W-1:0]      asid,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  logic [ENTRIES-1:0] m;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic glob;
    assign glob = ents[i].g0 & ents[i].g1;
    assign m[i] = (ents[i].vpn2 == tag) && (glob || (ents[i].asid == asid));
  end

  // lowest index wins
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);
    end
  end

  assign found = |m;
endmodule

// File: rtl/vtlb_range.sv
module vtlb_range
  import vtlb_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic            mode64,
  input  logic            user,
  output logic [EA_W-1:0] ea,
  output logic            aerr
);
  logic beyond;

  assign ea     = mode64 ? va[EA_W-1:0] : EA_W'(va[31:0]);
  assign beyond = mode64 ? (|va[VA_W-1:EA_W]) : va[U32_W];
  assign aerr   = user & beyond;
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_mode64,
  input  logic              lk_user,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g0,
  input  logic              wr_g1,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_aerr,
  output logic [PA_W-1:0]   rsp_pa
);
  tlb_ent_t                 wdata;
  tlb_ent_t [ENTRIES-1:0]   ents;
  tlb_ent_t                 sel;
  logic [EA_W-1:0]          ea;
  logic                     aerr;
  logic                     found;
  logic [IDX_W-1:0]         idx;
  logic                     odd;
  logic                     half_ok;
  logic [PFN_W-1:0]         pfn;
  logic                     hit_c;

  assign wdata = '{vpn2: wr_vpn2, asid: wr_asid, g0: wr_g0, g1: wr_g1,
                   v0: wr_v0, v1: wr_v1, pfn0: wr_pfn0, pfn1: wr_pfn1};

  vtlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(wdata), .ents_o(ents)
  );

  vtlb_range u_range (
    .va(lk_va), .mode64(lk_mode64), .user(lk_user), .ea(ea), .aerr(aerr)
  );

  vtlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ents(ents), .tag(ea[EA_W-1:OFF_W+1]), .asid(lk_asid), .found(found), .idx(idx)
  );

  assign sel     = ents[idx];
  assign odd     = ea[OFF_W];
  assign half_ok = odd ? sel.v1 : sel.v0;
  assign pfn     = odd ? sel.pfn1 : sel.pfn0;
  assign hit_c   = lk_req && !aerr && found && half_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_hit  <= 1'b0;
      rsp_miss <= 1'b0;
      rsp_aerr <= 1'b0;
      rsp_pa   <= '0;
    end else begin
      rsp_vld  <= lk_req;
      rsp_hit  <= hit_c;
      rsp_miss <= lk_req && !aerr && !(found && half_ok);
      rsp_aerr <= lk_req && aerr;
      rsp_pa   <= hit_c ? {pfn, ea[OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic [VA_W-1:0]   lk_va,
  input logic              lk_mode64,
  input logic              lk_user,
  input logic              rsp_vld,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_aerr,
  input logic [PA_W-1:0]   rsp_pa
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_vld); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_vld); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> ($countones({rsp_hit, rsp_miss, rsp_aerr}) == 1)); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> !(rsp_hit || rsp_miss || rsp_aerr)); // R2
  AST_ERR_RANGE32: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_user && !lk_mode64 && lk_va[U32_W]) |=> rsp_aerr); // R3
  AST_ERR_RANGE64: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_user && lk_mode64 && (|lk_va[VA_W-1:EA_W])) |=> rsp_aerr); // R4
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (!rsp_hit || (rsp_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])))); // R6
  AST_PA_ZERO_NOHIT: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_pa == '0)); // R6
endmodule

bind vtlb_top vtlb_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/test_vtlb_top.sv
module test_vtlb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 0, lk_mode64 = 0, lk_user = 0;
  logic [63:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        wr_en = 0, wr_g0 = 0, wr_g1 = 0, wr_v0 = 0, wr_v1 = 0;
  logic [4:0]  wr_idx = '0;
  logic [26:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic        rsp_vld, rsp_hit, rsp_miss, rsp_aerr;
  logic [31:0] rsp_pa;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  logic [26:0] m_tag [32];
  logic [7:0]  m_asid [32];
  bit          m_g0 [32], m_g1 [32], m_v0 [32], m_v1 [32];
  logic [19:0] m_p0 [32], m_p1 [32];

  bit          e_vld, e_hit, e_miss, e_aerr;
  logic [31:0] e_pa;

  always #2 clk = ~clk;

  vtlb_top i_vtlb_top (.*);

  function automatic logic [39:0] eff(logic [63:0] va, bit m64);
    return m64 ? va[39:0] : {8'h00, va[31:0]};
  endfunction

  task automatic model_eval();
    logic [39:0] ea;
    int          w;
    bit          bad;
    e_vld = lk_req; e_hit = 0; e_miss = 0; e_aerr = 0; e_pa = '0;
    if (!lk_req) return;
    ea  = eff(lk_va, lk_mode64);
    bad = lk_user && (lk_mode64 ? (lk_va[63:40] != 0) : lk_va[31]);
    if (bad) begin e_aerr = 1; return; end
    w = -1;
    for (int i = 0; i < 32; i++)
      if (w < 0 && m_tag[i] == ea[39:13] && ((m_g0[i] && m_g1[i]) || m_asid[i] == lk_asid))
        w = i;
    if (w >= 0 && (ea[12] ? m_v1[w] : m_v0[w])) begin
      e_hit = 1;
      e_pa  = {(ea[12] ? m_p1[w] : m_p0[w]), ea[11:0]};
    end else e_miss = 1;
  endtask

  task automatic model_write();
    if (!wr_en) return;
    m_tag[wr_idx] = wr_vpn2; m_asid[wr_idx] = wr_asid;
    m_g0[wr_idx] = wr_g0; m_g1[wr_idx] = wr_g1;
    m_v0[wr_idx] = wr_v0; m_v1[wr_idx] = wr_v1;
    m_p0[wr_idx] = wr_pfn0; m_p1[wr_idx] = wr_pfn1;
  endtask

  task automatic compare(input string rq);
    n_cmp++;
    if ({rsp_vld, rsp_hit, rsp_miss, rsp_aerr} !== {e_vld, e_hit, e_miss, e_aerr} || rsp_pa !== e_pa) begin
      n_bad++;
      $display("FAIL %s: got vld/hit/miss/aerr=%b%b%b%b pa=%h, expected %b%b%b%b pa=%h",
               rq, rsp_vld, rsp_hit, rsp_miss, rsp_aerr, rsp_pa,
               e_vld, e_hit, e_miss, e_aerr, e_pa);
    end
  endtask

  // one clock: inputs already driven at negedge
  task automatic step(input string rq);
    model_eval();
    model_write();
    @(posedge clk); #1;
    compare(rq);
    @(negedge clk);
    lk_req = 0; wr_en = 0;
  endtask

  task automatic set_lk(input logic [63:0] va, input logic [7:0] asid, input bit m64, input bit usr);
    lk_req = 1; lk_va = va; lk_asid = asid; lk_mode64 = m64; lk_user = usr;
  endtask

  task automatic set_wr(input int idx, input logic [26:0] tag, input logic [7:0] asid,
                        input bit g0, input bit g1, input bit v0, input bit v1,
                        input logic [19:0] p0, input logic [19:0] p1);
    wr_en = 1; wr_idx = 5'(idx); wr_vpn2 = tag; wr_asid = asid;
    wr_g0 = g0; wr_g1 = g1; wr_v0 = v0; wr_v1 = v1; wr_pfn0 = p0; wr_pfn1 = p1;
  endtask

  function automatic logic [63:0] va_of(logic [26:0] tag, bit odd, logic [11:0] off);
    return {24'h0, tag, odd, off};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_tag[i] = '0; m_asid[i] = '0; m_g0[i] = 0; m_g1[i] = 0;
      m_v0[i] = 0; m_v1[i] = 0; m_p0[i] = '0; m_p1[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R12: outputs cleared by reset
    e_vld = 0; e_hit = 0; e_miss = 0; e_aerr = 0; e_pa = '0;
    compare("R12");
    rst = 0;
    set_lk(va_of(27'h0, 0, 12'h0), 8'd0, 1, 1); step("R12");
    step("R1");
    // R11: write and lookup to the same page in one cycle sees old contents
    set_wr(5, 27'h0A5A5A, 8'd3, 0, 0, 1, 1, 20'hAAAAA, 20'hBBBBB);
    set_lk(va_of(27'h0A5A5A, 0, 12'h123), 8'd3, 1, 1); step("R11");
    set_lk(va_of(27'h0A5A5A, 0, 12'h123), 8'd3, 1, 1); step("R6");
    set_lk(va_of(27'h0A5A5A, 1, 12'hFFF), 8'd3, 1, 0); step("R8");
    set_lk(va_of(27'h0A5A5A, 0, 12'h010), 8'd4, 1, 1); step("R7");
    // R7: global entry matches any identifier
    set_wr(9, 27'h0A5A5A, 8'd77, 1, 1, 1, 1, 20'h11111, 20'h22222); step("R11");
    set_lk(va_of(27'h0A5A5A, 0, 12'h010), 8'd4, 1, 1); step("R7");
    // R10: lowest index wins
    set_lk(va_of(27'h0A5A5A, 1, 12'h020), 8'd3, 1, 1); step("R10");
    set_wr(2, 27'h0A5A5A, 8'd3, 0, 0, 0, 1, 20'h33333, 20'h44444);
    set_lk(va_of(27'h0A5A5A, 1, 12'h030), 8'd3, 1, 1); step("R11");
    set_lk(va_of(27'h0A5A5A, 1, 12'h030), 8'd3, 1, 1); step("R10");
    set_lk(va_of(27'h0A5A5A, 0, 12'h030), 8'd3, 1, 1); step("R9");
    // R9: invalid odd half
    set_wr(7, 27'h000123, 8'd1, 0, 0, 1, 0, 20'h55555, 20'h66666); step("R11");
    set_lk(va_of(27'h000123, 1, 12'h0), 8'd1, 1, 1); step("R9");
    set_lk(va_of(27'h000123, 0, 12'h0), 8'd1, 1, 1); step("R8");
    // R7: only one global flag set is not global
    set_wr(8, 27'h000456, 8'd1, 1, 0, 1, 1, 20'h77777, 20'h88888); step("R11");
    set_lk(va_of(27'h000456, 0, 12'h0), 8'd2, 1, 1); step("R7");
    // R3: 32-bit mode
    set_wr(12, eff(64'hDEAD_BEEF_0012_3456, 0) >> 13, 8'd6, 0, 0, 1, 1, 20'h9ABCD, 20'hCDEF0); step("R11");
    set_lk(64'hDEAD_BEEF_0012_3456, 8'd6, 0, 1); step("R3");
    set_lk(64'h0000_0000_8012_3456, 8'd6, 0, 1); step("R3");
    set_lk(64'h0000_0000_8012_3456, 8'd6, 0, 0); step("R3");
    // R4 / R5: 64-bit range and tag width
    set_wr(13, 27'h7800001, 8'd6, 0, 0, 1, 1, 20'h0F0F0, 20'h0E0E0); step("R11");
    set_lk(64'h0000_00F0_0000_2ABC, 8'd6, 1, 1); step("R5");
    set_lk(64'h0000_00F0_0000_2ABC, 8'd6, 0, 1); step("R5");
    set_lk(64'h0000_01F0_0000_2ABC, 8'd6, 1, 1); step("R4");
    set_lk(64'h8000_01F0_0000_2ABC, 8'd6, 1, 0); step("R4");
    // R11: overwrite at the same edge as a lookup of the old entry
    set_wr(13, 27'h7800001, 8'd6, 0, 0, 0, 0, 20'h0, 20'h0);
    set_lk(64'h0000_00F0_0000_2ABC, 8'd6, 1, 1); step("R11");
    set_lk(64'h0000_00F0_0000_2ABC, 8'd6, 1, 1); step("R11");
    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic [26:0] t;
      t = 27'(($urandom % 4) * 27'h1111 + 27'h40);
      if ($urandom % 3 == 0)
        set_wr($urandom % 32, t, 8'($urandom % 3), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 20'($urandom), 20'($urandom));
      if ($urandom % 4 != 0) begin
        logic [63:0] v;
        v = va_of(t, 1'($urandom), 12'($urandom));
        if ($urandom % 8 == 0) v[63:40] = 24'($urandom);
        if ($urandom % 8 == 0) v[31] = 1'b1;
        set_lk(v, 8'($urandom % 3), 1'($urandom), 1'($urandom));
      end
      step("R10");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired, got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule